// File: doc/BRIEF.md
# Programmable Wait-State Generator

This block decides how long each external bus access lasts, so that slow off-chip memories and peripherals can be attached without glue logic. When the bus sequencer flags the start of an access, the block looks up a programmed wait count of zero to seven for the selected address space. It keeps the sequencer on hold for that many extra clock cycles, then keeps it on hold for as long as the external ready line stays low. It pulses a completion flag in the final cycle of the access.

Accesses to internal memory bypass both the programmed count and the ready line and finish in their first cycle. External writes never finish in fewer than two cycles, which gives the data bus time to change direction. Wait counts for the program, data and I/O spaces live in one writable configuration register. The register resets to the slowest setting.

Top module: `ws_gen`

## Requirements
- R1: After a synchronous reset the configuration output reads 9'h1FF (seven wait states for every space), and both `hold` and `done` are low while no access is requested.
- R2: An external read with a programmed count N and `ready_in` high completes N cycles after its start cycle. The start cycle is counted as cycle 0, so a read with N = 0 completes in its start cycle. `hold` is high in every earlier cycle of the access.
- R3: An external write with programmed count N completes in cycle max(N,1) after its start cycle, so it always lasts at least two cycles.
- R4: Once the programmed count has expired, every cycle in which `ready_in` is low adds one cycle to an external access. The access completes in the first such cycle in which `ready_in` is high.
- R5: `ready_in` is ignored while programmed wait cycles remain. A low level during those cycles neither delays nor advances completion.
- R6: An internal access (`cyc_internal` = 1) completes in its start cycle, whatever the programmed count, the access type or `ready_in`.
- R7: The space code selects the count field. Code 0 (program) uses bits [2:0], code 1 (data) uses bits [5:3], code 2 (I/O) uses bits [8:6], and code 3 is treated as data.
- R8: `done` is high for exactly one cycle per access, and never together with `hold`. No cycle after completion belongs to the finished access.
- R9: `cyc_start` and the access attributes are ignored while an access is in progress, including its completion cycle.
- R10: A configuration write is visible on `cfg_q` from the next cycle. An access that starts in the same cycle as the write uses the old count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all wait states align to its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the wait-count register |
| cfg_wdata | input | 9 | New register value: program [2:0], data [5:3], I/O [8:6] |
| cfg_q | output | 9 | Current wait-count register value |
| cyc_start | input | 1 | First cycle of a new bus access |
| cyc_write | input | 1 | Access is a write (1) or a read (0) |
| cyc_internal | input | 1 | Access targets internal memory |
| cyc_space | input | 2 | Space code: 0 program, 1 data, 2 I/O, 3 data |
| ready_in | input | 1 | External ready line, sampled at clock edges |
| hold | output | 1 | Keep the bus sequencer in the current access |
| done | output | 1 | One-cycle pulse in the final cycle of an access |

## Verification
Two functions can fall in the same cycle: a configuration write, and the start of an access whose length depends on that configuration. The bench provokes this directed and at random, by raising `cfg_we` with a new value in the very cycle `cyc_start` is high. It then requires the access length to follow the old count while `cfg_q` shows the new one a cycle later. A second overlap, a spurious `cyc_start` in the completion cycle of a longer access, is judged by requiring that no further cycle of `hold` or `done` follows.

// File: rtl/ws_pkg.sv
package ws_pkg;

    parameter int WS_W       = 3;
    parameter int NUM_SPACES = 3;
    parameter int CFG_W      = WS_W * NUM_SPACES;
    parameter int SPACE_W    = 2;
    parameter logic [WS_W-1:0] RESET_WS = '1;

    typedef enum logic [SPACE_W-1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_ALT  = 2'd3
    } space_e;

    typedef struct packed {
        logic   write;
        logic   internal;
        space_e space;
    } acc_req_t;

    typedef struct packed {
        logic            busy;
        logic [WS_W-1:0] cnt;
    } seq_state_t;

    // Field index used for a space code; the spare code maps to data.
    function automatic int unsigned field_index(input space_e sp);
        case (sp)
            SP_PROG: return 0;
            SP_DATA: return 1;
            SP_IO:   return 2;
            default: return 1;
        endcase
    endfunction

    // Writes need at least one wait cycle to turn the bus around.
    function automatic logic [WS_W-1:0] effective_wait(input logic [WS_W-1:0] n,
                                                        input logic write);
        if (write && (n == '0))
            return {{(WS_W-1){1'b0}}, 1'b1};
        return n;
    endfunction

endpackage

// File: rtl/ws_cfg_reg.sv
module ws_cfg_reg
    import ws_pkg::*;
#(
    parameter int FIELD_W = WS_W,
    parameter int FIELDS  = NUM_SPACES,
    parameter logic [FIELD_W-1:0] FIELD_RST = RESET_WS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [FIELD_W*FIELDS-1:0] wdata,
    output logic [FIELD_W*FIELDS-1:0] q
);

    localparam int TOTAL_W = FIELD_W * FIELDS;
    localparam logic [TOTAL_W-1:0] RESET_VAL = {FIELDS{FIELD_RST}};

    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        logic [FIELD_W-1:0] field_q;
        always_ff @(posedge clk) begin
            if (rst)
                field_q <= FIELD_RST;
            else if (we)
                field_q <= wdata[f*FIELD_W +: FIELD_W];
        end
        assign q[f*FIELD_W +: FIELD_W] = field_q;
    end

    // R1: every field returns to the slowest setting after reset
    assert_cfg_reset_R1: assert property (@(posedge clk) rst |=> (q == RESET_VAL));

    // R10: without a write strobe the register keeps its value
    assert_cfg_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R10: a write is visible one cycle later
    assert_cfg_write_R10: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));

endmodule

// File: rtl/ws_space_mux.sv
module ws_space_mux
    import ws_pkg::*;
#(
    parameter int FIELD_W = WS_W,
    parameter int FIELDS  = NUM_SPACES
) (
    input  logic [FIELD_W*FIELDS-1:0] cfg,
    input  space_e                    space,
    output logic [FIELD_W-1:0]        wait_n
);

    logic [FIELD_W-1:0] fields [FIELDS];

    for (genvar f = 0; f < FIELDS; f++) begin : g_split
        assign fields[f] = cfg[f*FIELD_W +: FIELD_W];
    end

    always_comb begin
        wait_n = '0;
        for (int f = 0; f < FIELDS; f++) begin
            if (field_index(space) == f)
                wait_n = fields[f];
        end
    end

endmodule

// File: rtl/ws_sequencer.sv
module ws_sequencer
    import ws_pkg::*;
#(
    parameter int CNT_W = WS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  acc_req_t         req,
    input  logic [CNT_W-1:0] wait_n,
    input  logic             ready,
    output logic             hold,
    output logic             done
);

    seq_state_t st_q, st_d;
    logic       first;
    logic       active;
    logic [CNT_W-1:0] eff_n;

    assign first  = start && !st_q.busy;
    assign active = start || st_q.busy;
    assign eff_n  = effective_wait(wait_n, req.write);

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else if (ready) begin
                done      = 1'b1;
                st_d.busy = 1'b0;
            end
        end else if (start) begin
            if (req.internal) begin
                done = 1'b1;
            end else if (eff_n == '0) begin
                if (ready) begin
                    done = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                end
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = eff_n - 1'b1;
            end
        end
    end

    assign hold = active && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: while programmed waits remain, completion is impossible
    assert_wait_blocks_done_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.cnt != '0) |-> !done);

    // R2: each wait cycle advances the count by exactly one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.cnt != '0) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R3: an external write never completes in its start cycle
    assert_write_min_R3: assert property (@(posedge clk) disable iff (rst)
        (first && !req.internal && req.write) |-> !done);

    // R4: a low ready after expiry keeps the access open
    assert_ready_stretch_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.cnt == '0 && !ready) |=> (st_q.busy && st_q.cnt == '0));

    // R6: internal accesses finish in their start cycle
    assert_internal_done_R6: assert property (@(posedge clk) disable iff (rst)
        (first && req.internal) |-> done);

    // R8: nothing of the access remains after its completion
    assert_done_closes_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !st_q.busy);

    // R9: a start request during an open access does not end it
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && start && !done) |=> st_q.busy);

endmodule

// File: rtl/ws_gen.sv
module ws_gen
    import ws_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_q,
    input  logic               cyc_start,
    input  logic               cyc_write,
    input  logic               cyc_internal,
    input  logic [SPACE_W-1:0] cyc_space,
    input  logic               ready_in,
    output logic               hold,
    output logic               done
);

    acc_req_t        req;
    logic [WS_W-1:0] wait_n;

    assign req.write    = cyc_write;
    assign req.internal = cyc_internal;
    assign req.space    = space_e'(cyc_space);

    ws_cfg_reg #(
        .FIELD_W  (WS_W),
        .FIELDS   (NUM_SPACES),
        .FIELD_RST(RESET_WS)
    ) i_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .wdata(cfg_wdata),
        .q    (cfg_q)
    );

    ws_space_mux #(
        .FIELD_W(WS_W),
        .FIELDS (NUM_SPACES)
    ) i_mux (
        .cfg   (cfg_q),
        .space (req.space),
        .wait_n(wait_n)
    );

    ws_sequencer #(
        .CNT_W(WS_W)
    ) i_seq (
        .clk   (clk),
        .rst   (rst),
        .start (cyc_start),
        .req   (req),
        .wait_n(wait_n),
        .ready (ready_in),
        .hold  (hold),
        .done  (done)
    );

    // R8: the hold and completion outputs are mutually exclusive
    assert_hold_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(hold && done));

endmodule

// File: tb/test_ws_gen.sv
module test_ws_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [8:0] cfg_wdata;
    logic [8:0] cfg_q;
    logic       cyc_start, cyc_write, cyc_internal;
    logic [1:0] cyc_space;
    logic       ready_in;
    logic       hold, done;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    bit          ended  = 1'b0;
    logic [8:0]  m_cfg;

    always #10 clk = ~clk;   // 50 MHz

    ws_gen i_ws_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .cyc_start(cyc_start), .cyc_write(cyc_write), .cyc_internal(cyc_internal),
        .cyc_space(cyc_space), .ready_in(ready_in), .hold(hold), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R7: field choice per space code, code 3 -> data
    function automatic int field_of(input logic [8:0] c, input logic [1:0] sp);
        case (sp)
            2'd0:    return int'(c[2:0]);
            2'd2:    return int'(c[8:6]);
            default: return int'(c[5:3]);
        endcase
    endfunction

    function automatic int eff_of(input int n, input logic wr);
        return (wr && n == 0) ? 1 : n;   // R3
    endfunction

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            cyc_start = 1'b0; cfg_we = 1'b0;
            cyc_write = 1'($urandom); cyc_internal = 1'($urandom);
            cyc_space = 2'($urandom); ready_in = 1'($urandom);
            #1;
            check(hold == 1'b0 && done == 1'b0, "R8 idle", {hold, done}, 0);
        end
    endtask

    task automatic cfg_write(input logic [8:0] v);
        @(negedge clk);
        cyc_start = 1'b0; cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        m_cfg = v;
        #1;
        check(cfg_q == m_cfg, "R10 cfg readback", int'(cfg_q), int'(m_cfg));
    endtask

    // One access; k = extra cycles with ready low after the count expires.
    task automatic run_access(input logic [1:0] sp, input logic wr, input logic intl,
                              input int k, input bit same_wr, input logic [8:0] new_cfg,
                              input bit spurious);
        int eff, last;
        string tag;
        eff  = eff_of(field_of(m_cfg, sp), wr);
        last = intl ? 0 : eff + k;
        tag  = intl ? "R6 internal" : (k > 0 ? "R4 ready stretch" : (wr ? "R3 write" : "R2 read"));
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);
            cfg_we = (i == 0) && same_wr;
            cfg_wdata = new_cfg;
            if (i == 0) begin
                cyc_start = 1'b1; cyc_write = wr; cyc_internal = intl; cyc_space = sp;
            end else begin
                // R9: later start requests and attributes are noise
                cyc_start = spurious ? 1'($urandom) : 1'b0;
                cyc_write = 1'($urandom); cyc_internal = 1'($urandom);
                cyc_space = 2'($urandom);
            end
            if (intl)          ready_in = 1'($urandom);        // R6
            else if (i < eff)  ready_in = 1'($urandom);        // R5
            else if (i < last) ready_in = 1'b0;                // R4
            else               ready_in = 1'b1;
            #1;
            check(done == (i == last), tag, int'(done), int'(i == last));
            check(hold == (i < last), tag, int'(hold), int'(i < last));
        end
        if (same_wr) m_cfg = new_cfg;   // R10: access used the old value
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; cyc_start = 1'b0;
        cyc_write = 1'b0; cyc_internal = 1'b0; cyc_space = '0; ready_in = 1'b1;
        m_cfg = 9'h1FF;
        repeat (3) @(negedge clk);
        #1;
        check(cfg_q == 9'h1FF, "R1 reset cfg", int'(cfg_q), 9'h1FF);
        check(hold == 1'b0 && done == 1'b0, "R1 reset outputs", {hold, done}, 0);
        @(negedge clk); rst = 1'b0;
        idle(2);

        // Directed corners
        run_access(2'd0, 1'b0, 1'b0, 0, 1'b0, 9'h0, 1'b0);       // R2 seven waits
        run_access(2'd1, 1'b1, 1'b1, 0, 1'b0, 9'h0, 1'b0);       // R6
        cfg_write(9'b011_000_101);                                // R7 io=3 data=0 prog=5
        run_access(2'd1, 1'b0, 1'b0, 0, 1'b0, 9'h0, 1'b0);       // R2 zero-wait read
        run_access(2'd1, 1'b1, 1'b0, 0, 1'b0, 9'h0, 1'b0);       // R3 two-cycle write
        run_access(2'd3, 1'b0, 1'b0, 0, 1'b0, 9'h0, 1'b0);       // R7 code 3 -> data
        run_access(2'd2, 1'b0, 1'b0, 0, 1'b0, 9'h0, 1'b0);       // R7 io
        run_access(2'd1, 1'b0, 1'b0, 20, 1'b0, 9'h0, 1'b0);      // R4 long stretch
        run_access(2'd0, 1'b1, 1'b0, 2, 1'b1, 9'h1C0, 1'b1);     // R10 same-cycle write, R9
        #1;
        check(cfg_q == 9'h1C0, "R10 new value visible", int'(cfg_q), 9'h1C0);
        run_access(2'd0, 1'b0, 1'b0, 0, 1'b0, 9'h0, 1'b1);       // uses new prog=0
        idle(1);

        // Constrained random traffic
        for (int t = 0; t < 400; t++) begin
            int r;
            r = int'($urandom % 10);
            if (r == 0) cfg_write(9'($urandom));
            run_access(2'($urandom), 1'($urandom), ($urandom % 4 == 0),
                       ($urandom % 3 == 0) ? int'($urandom % 5) : 0,
                       ($urandom % 8 == 0), 9'($urandom), ($urandom % 2 == 0));
            if ($urandom % 3 == 0) idle(1);
        end
        idle(2);
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_fail++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule